// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a narrow 16-bit register window reach registers of a device that has a wide address space and can only be accessed one word at a time through a request/acknowledge port. The host fills in the upper and middle parts of the target address in two address registers. For a write it also loads the data register. It then writes a command word to the control register. The command word carries the lowest address bits, the direction and a start flag.

After the start, the bridge holds a single 16-bit cycle open on the device port until the device acknowledges it. During that time it shows a busy flag in the control register, and the host polls that flag. When a read completes, the returned word sits in the data register. If the device never answers, the bridge gives up after a set number of clocks and raises a timeout flag. The flag stays set until the next accepted cycle. While the bridge is idle, reading the control register shows whether the device is present.

Top module: `ibr_bridge`

## Requirements
- R1: After reset `dev_req` is 0, and the control register (offset 0x0) reads 0x0001 while `dev_present` is 1.
- R2: A control write with bit 8 set and bits 13:12 not both 1 (for example 0x0101) starts a read cycle with `dev_we`=0. Once busy clears, the data register (offset 0x4) holds the `dev_rdata` word that was present with the acknowledge.
- R3: During a cycle, `dev_addr` bits 31:20 equal the high register (offset 0x8, 12 bits) and bits 19:4 equal the low register (offset 0xa). Bits 3:1 equal control bits 11:9 of the starting write, and bit 0 is 0.
- R4: A control write with bit 8 set and bits 13:12 equal to 2'b11 (for example 0x3101) starts a write cycle with `dev_we`=1 and `dev_wdata` equal to the data register.
- R5: Control bit 8 reads 1 from the clock after the starting write until the clock edge on which `dev_ack` is sampled high. It reads 0 after that edge, and `dev_req` falls on the same edge.
- R6: A control write with bit 8 clear (for example 0x3001) starts no cycle: `dev_req` stays 0 and bit 8 stays 0.
- R7: While a cycle is in progress, every host write (control, data, high, low) is ignored. The device port values stay stable and no second cycle starts.
- R8: If `dev_ack` does not arrive within TMO_CYCLES clocks of request, the cycle ends and control bit 15 is set. Bit 15 stays set until the next accepted cycle start, which clears it.
- R9: The high register keeps only its low 12 bits and reads back zero-extended. The low and data registers read back all 16 bits written.
- R10: Control bit 0 reflects `dev_present` directly, and all other control bits except 8 and 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_addr | input | HA_W (4) | Host register byte offset |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data for `hst_addr` (combinational) |
| dev_present | input | 1 | Device presence indication |
| dev_req | output | 1 | Device cycle request, held until acknowledge or timeout |
| dev_we | output | 1 | 1 for a device write cycle |
| dev_addr | output | DEV_AW (32) | Device word address |
| dev_wdata | output | 16 | Device write data |
| dev_rdata | input | 16 | Device read data, valid with acknowledge |
| dev_ack | input | 1 | Device acknowledge |

## Verification
The bench builds the bridge with the default address field widths (12 high bits, 16 low bits) but lowers TMO_CYCLES from 1024 to 12. This brings the timeout path within a few dozen clocks and lets the bench check the exact clock on which busy drops. With the short limit, the device model can answer after a delay of a few clocks and still stay well inside the window, so normal cycles and the timed-out cycle can both run in one bench. The full 32-bit address assembly is exercised with distinct values in every field.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
   localparam logic [3:0] OFS_CTRL = 4'h0;
   localparam logic [3:0] OFS_DATA = 4'h4;
   localparam logic [3:0] OFS_HIGH = 4'h8;
   localparam logic [3:0] OFS_LOW  = 4'hA;

   localparam int CB_PRES   = 0;
   localparam int CB_GO     = 8;
   localparam int CB_SUB_LO = 9;
   localparam int SUB_BITS  = 3;
   localparam int CB_DIR_LO = 12;
   localparam int CB_TMO    = 15;

   typedef struct packed {
      logic                we;
      logic [SUB_BITS-1:0] sub;
   } ibr_cmd_t;
endpackage

// File: rtl/ibr_regs.sv
module ibr_regs
   import ibr_pkg::*;
#(
   parameter int HA_W    = 4,
   parameter int DW      = 16,
   parameter int HI_BITS = 12,
   parameter int LO_BITS = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [HA_W-1:0]    wr_addr,
   input  logic [DW-1:0]      wr_data,
   input  logic               busy,
   input  logic               rd_load,
   input  logic [DW-1:0]      rd_word,
   output logic               start,
   output logic [HI_BITS-1:0] hi_q,
   output logic [LO_BITS-1:0] lo_q,
   output logic [DW-1:0]      data_q,
   output ibr_cmd_t           cmd_q
);
   logic accept;
   logic sel_ctrl, sel_data, sel_high, sel_low;

   assign accept   = wr_en && !busy;
   assign sel_ctrl = (wr_addr == HA_W'(OFS_CTRL));
   assign sel_data = (wr_addr == HA_W'(OFS_DATA));
   assign sel_high = (wr_addr == HA_W'(OFS_HIGH));
   assign sel_low  = (wr_addr == HA_W'(OFS_LOW));
   assign start    = accept && sel_ctrl && wr_data[CB_GO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         data_q <= '0;
         cmd_q  <= '0;
      end else begin
         if (accept && sel_high) hi_q <= wr_data[HI_BITS-1:0];
         if (accept && sel_low)  lo_q <= wr_data[LO_BITS-1:0];
         if (rd_load)
            data_q <= rd_word;
         else if (accept && sel_data)
            data_q <= wr_data;
         if (start) begin
            cmd_q.we  <= (wr_data[CB_DIR_LO+1:CB_DIR_LO] == 2'b11);
            cmd_q.sub <= wr_data[CB_SUB_LO+SUB_BITS-1:CB_SUB_LO];
         end
      end
   end
endmodule

// File: rtl/ibr_seq.sv
module ibr_seq #(
   parameter int TMO_CYCLES = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ack,
   input  logic we,
   output logic busy,
   output logic rd_load,
   output logic tmo_flag
);
   logic busy_q;
   logic tmo_q;

   generate
      if (TMO_CYCLES > 0) begin : g_timer
         localparam int CW = $clog2(TMO_CYCLES + 1);
         localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               tmo_q  <= 1'b0;
               cnt_q  <= '0;
            end else if (start) begin
               busy_q <= 1'b1;
               tmo_q  <= 1'b0;
               cnt_q  <= '0;
            end else if (busy_q) begin
               if (ack) begin
                  busy_q <= 1'b0;
               end else if (cnt_q == LAST) begin
                  busy_q <= 1'b0;
                  tmo_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end else begin : g_wait
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               busy_q <= 1'b0;
            else if (start)
               busy_q <= 1'b1;
            else if (busy_q && ack)
               busy_q <= 1'b0;
         end
         assign tmo_q = 1'b0;
      end
   endgenerate

   assign busy     = busy_q;
   assign tmo_flag = tmo_q;
   assign rd_load  = busy_q && ack && !we;
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
   import ibr_pkg::*;
#(
   parameter int HA_W       = 4,
   parameter int HI_BITS    = 12,
   parameter int LO_BITS    = 16,
   parameter int TMO_CYCLES = 1024,
   localparam int DW        = 16,
   localparam int DEV_AW    = HI_BITS + LO_BITS + SUB_BITS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_wr,
   input  logic [HA_W-1:0]   hst_addr,
   input  logic [DW-1:0]     hst_wdata,
   output logic [DW-1:0]     hst_rdata,
   input  logic              dev_present,
   output logic              dev_req,
   output logic              dev_we,
   output logic [DEV_AW-1:0] dev_addr,
   output logic [DW-1:0]     dev_wdata,
   input  logic [DW-1:0]     dev_rdata,
   input  logic              dev_ack
);
   generate
      if (HA_W < 4) begin : g_bad_ha
         $error("HA_W must cover offsets up to 0xA");
      end
      if (HI_BITS < 1 || HI_BITS > DW) begin : g_bad_hi
         $error("HI_BITS must be 1..16");
      end
      if (LO_BITS < 1 || LO_BITS > DW) begin : g_bad_lo
         $error("LO_BITS must be 1..16");
      end
      if (TMO_CYCLES < 0) begin : g_bad_tmo
         $error("TMO_CYCLES must not be negative");
      end
   endgenerate

   logic               start;
   logic               busy;
   logic               rd_load;
   logic               tmo_flag;
   logic [HI_BITS-1:0] hi_q;
   logic [LO_BITS-1:0] lo_q;
   logic [DW-1:0]      data_q;
   ibr_cmd_t           cmd_q;

   ibr_regs #(
      .HA_W(HA_W), .DW(DW), .HI_BITS(HI_BITS), .LO_BITS(LO_BITS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(hst_wr), .wr_addr(hst_addr), .wr_data(hst_wdata),
      .busy(busy), .rd_load(rd_load), .rd_word(dev_rdata),
      .start(start), .hi_q(hi_q), .lo_q(lo_q), .data_q(data_q), .cmd_q(cmd_q)
   );

   ibr_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .ack(dev_ack), .we(cmd_q.we),
      .busy(busy), .rd_load(rd_load), .tmo_flag(tmo_flag)
   );

   assign dev_req   = busy;
   assign dev_we    = cmd_q.we;
   assign dev_wdata = data_q;
   assign dev_addr  = {hi_q, lo_q, cmd_q.sub, 1'b0};

   logic [DW-1:0] ctrl_view;
   always_comb begin
      ctrl_view          = '0;
      ctrl_view[CB_PRES] = dev_present;
      ctrl_view[CB_GO]   = busy;
      ctrl_view[CB_TMO]  = tmo_flag;
   end

   always_comb begin
      unique case (hst_addr)
         HA_W'(OFS_CTRL): hst_rdata = ctrl_view;
         HA_W'(OFS_DATA): hst_rdata = data_q;
         HA_W'(OFS_HIGH): hst_rdata = DW'(hi_q);
         HA_W'(OFS_LOW):  hst_rdata = DW'(lo_q);
         default:         hst_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk
   import ibr_pkg::*;
#(
   parameter int HA_W       = 4,
   parameter int DEV_AW     = 32,
   parameter int TMO_CYCLES = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_wr,
   input logic [HA_W-1:0]   hst_addr,
   input logic              hst_go,
   input logic              dev_req,
   input logic              dev_we,
   input logic [DEV_AW-1:0] dev_addr,
   input logic [15:0]       dev_wdata,
   input logic              dev_ack,
   input logic              busy,
   input logic              tmo_flag,
   input logic [15:0]       data_q
);
   // R5: the request ends on the acknowledge edge
   a_r5_req_drops_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req && dev_ack |=> !dev_req);

   // R7: device port is held steady while a cycle waits
   a_r7_port_stable: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req && !dev_ack |=> !dev_req ||
         ($stable(dev_addr) && $stable(dev_we) && $stable(dev_wdata)));

   // R6: a cycle only begins after a control write with the start bit
   a_r6_start_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_req) |-> $past(hst_wr && hst_addr == HA_W'(OFS_CTRL) && hst_go));

   // R2: data register changes only by an idle host write or a read completion
   a_r2_data_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_q) |->
         $past(hst_wr && hst_addr == HA_W'(OFS_DATA) && !busy) ||
         $past(dev_req && dev_ack && !dev_we));

   // R8: timeout flag rises only when a request went unanswered, and ends it
   a_r8_tmo_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_flag) |-> $past(dev_req && !dev_ack) && !dev_req);

   generate
      if (TMO_CYCLES > 0) begin : g_win
         localparam int RW = $clog2(TMO_CYCLES + 1) + 1;
         logic [RW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       run_q <= '0;
            else if (dev_req) run_q <= run_q + 1'b1;
            else              run_q <= '0;
         end
         // R8: no request lasts beyond the timeout window
         a_r8_window: assert property (@(posedge clk) disable iff (!rst_n)
            dev_req |-> (run_q < RW'(TMO_CYCLES)));
      end
   endgenerate
endmodule

bind ibr_bridge ibr_bridge_chk #(
   .HA_W(HA_W), .DEV_AW(DEV_AW), .TMO_CYCLES(TMO_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
   .hst_go(hst_wdata[ibr_pkg::CB_GO]), .dev_req(dev_req), .dev_we(dev_we),
   .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
   .busy(busy), .tmo_flag(tmo_flag), .data_q(data_q)
);

// File: tb/tb_ibr_bridge.sv
module tb_ibr_bridge;
   localparam int TMO = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_wr = 1'b0;
   logic [3:0]  hst_addr = 4'h0;
   logic [15:0] hst_wdata = 16'h0;
   logic [15:0] hst_rdata;
   logic        dev_present = 1'b1;
   logic        dev_req, dev_we;
   logic [31:0] dev_addr;
   logic [15:0] dev_wdata;
   logic [15:0] dev_rdata = 16'h0;
   logic        dev_ack = 1'b0;

   int checks = 0;
   int fails  = 0;
   int dly    = 2;
   bit mute   = 1'b0;
   int wcnt   = 0;

   typedef struct {
      logic        we;
      logic [31:0] addr;
      logic [15:0] wd;
   } xact_t;
   xact_t exp_q[$];

   always #2 clk = ~clk;

   ibr_bridge #(.TMO_CYCLES(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dev_present(dev_present),
      .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ack(dev_ack)
   );

   function automatic logic [15:0] dev_word(input logic [31:0] a);
      return a[15:0] ^ a[31:16] ^ 16'h5A3C;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // device model and scoreboard monitor
   always @(negedge clk) begin
      if (dev_req && !dev_ack && !mute) begin
         if (wcnt >= dly) begin
            dev_ack   = 1'b1;
            dev_rdata = dev_word(dev_addr);
            wcnt      = 0;
            if (exp_q.size() == 0) begin
               chk("R7 unexpected cycle", 32'd1, 32'd0);
            end else begin
               xact_t e;
               e = exp_q.pop_front();
               chk(e.we ? "R4 direction" : "R2 direction", {31'd0, dev_we}, {31'd0, e.we});
               chk("R3 address", dev_addr, e.addr);
               if (e.we) chk("R4 write data", {16'd0, dev_wdata}, {16'd0, e.wd});
            end
         end else begin
            wcnt++;
         end
      end else begin
         dev_ack = 1'b0;
         if (!dev_req) wcnt = 0;
      end
   end

   task automatic hwrite(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      @(posedge clk);
      #1 hst_wr = 1'b0;
   endtask

   task automatic hread(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      hst_addr = a;
      #1 d = hst_rdata;
   endtask

   task automatic wait_idle(input string req);
      logic [15:0] v;
      for (int i = 0; i < 100; i++) begin
         hread(4'h0, v);
         if (!v[8]) return;
      end
      chk(req, 32'd1, 32'd0);
   endtask

   initial begin : watchdog
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [15:0] v;
      logic [31:0] ra, wa;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      hread(4'h0, v);
      chk("R1 ctrl after reset", {16'd0, v}, 32'h0001);
      chk("R1 req after reset", {31'd0, dev_req}, 32'd0);

      // R10 presence reflection
      dev_present = 1'b0;
      hread(4'h0, v);
      chk("R10 ctrl absent", {16'd0, v}, 32'h0000);
      dev_present = 1'b1;
      hread(4'h0, v);
      chk("R10 ctrl present", {16'd0, v}, 32'h0001);

      // R9 register readback
      hwrite(4'h8, 16'hFABC);
      hwrite(4'hA, 16'h1234);
      hwrite(4'h4, 16'hBEEF);
      hread(4'h8, v); chk("R9 high readback", {16'd0, v}, 32'h0ABC);
      hread(4'hA, v); chk("R9 low readback", {16'd0, v}, 32'h1234);
      hread(4'h4, v); chk("R9 data readback", {16'd0, v}, 32'hBEEF);

      // R2/R3/R5 read cycle
      ra = {12'hABC, 16'h1234, 3'b101, 1'b0};
      exp_q.push_back('{1'b0, ra, 16'h0});
      hwrite(4'h0, 16'h0101 | (16'h5 << 9));
      hread(4'h0, v);
      chk("R5 busy during cycle", {16'd0, v}, 32'h0101);
      wait_idle("R5 busy never cleared");
      chk("R5 req low after ack", {31'd0, dev_req}, 32'd0);
      hread(4'h4, v);
      chk("R2 read data", {16'd0, v}, {16'd0, dev_word(ra)});

      // R4/R7 write cycle with writes during busy
      dly = 5;
      hwrite(4'h4, 16'h1357);
      wa = {12'hABC, 16'h1234, 3'b010, 1'b0};
      exp_q.push_back('{1'b1, wa, 16'h1357});
      hwrite(4'h0, 16'h3101 | (16'h2 << 9));
      hwrite(4'h4, 16'hFFFF);
      hwrite(4'h8, 16'h0111);
      hwrite(4'h0, 16'h0101);
      wait_idle("R7 busy never cleared");
      repeat (3) @(negedge clk);
      chk("R7 req idle after ignored start", {31'd0, dev_req}, 32'd0);
      hread(4'h4, v); chk("R7 data kept", {16'd0, v}, 32'h1357);
      hread(4'h8, v); chk("R7 high kept", {16'd0, v}, 32'h0ABC);
      chk("R7 no extra cycle", exp_q.size(), 32'd0);

      // R6 start bit clear
      hwrite(4'h0, 16'h3001);
      hread(4'h0, v);
      chk("R6 no busy", {16'd0, v}, 32'h0001);
      chk("R6 no req", {31'd0, dev_req}, 32'd0);

      // R8 timeout
      mute = 1'b1;
      hwrite(4'h0, 16'h0101);
      repeat (TMO) @(negedge clk);
      #1 chk("R8 still busy at limit", {31'd0, dev_req}, 32'd1);
      @(negedge clk);
      #1 chk("R8 req dropped at limit", {31'd0, dev_req}, 32'd0);
      hread(4'h0, v); chk("R8 timeout flag", {16'd0, v}, 32'h8001);
      repeat (4) @(negedge clk);
      hread(4'h0, v); chk("R8 flag sticky", {16'd0, v}, 32'h8001);
      mute = 1'b0;
      dly = 1;

      // R8 cleared by next start
      ra = {12'hABC, 16'h1234, 3'b000, 1'b0};
      exp_q.push_back('{1'b0, ra, 16'h0});
      hwrite(4'h0, 16'h0101);
      wait_idle("R8 busy never cleared");
      hread(4'h0, v); chk("R8 flag cleared", {16'd0, v}, 32'h0001);
      hread(4'h4, v); chk("R2 second read data", {16'd0, v}, {16'd0, dev_word(ra)});
      chk("R3 scoreboard drained", exp_q.size(), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule